// File: doc/BRIEF.md
# Flash-Driver Register Target on a Two-Wire Bus

This block is the register front end of an LED flash driver. It watches the two-wire serial clock and data lines, both sampled by a faster system clock. It answers one 7-bit device address and keeps three writable 8-bit registers: command, dimming and auxiliary LED. A fourth location reads back status bits that are supplied from outside. Writes start at a register index that the master sends after the device address, and the index advances after each data byte. Reads set the index with a write phase, then send a repeated START and the device address with the read bit set. The target then returns bytes for as long as the master acknowledges them.

Bit 7 of the command register is the power bit. While it is 0, the device is powered down and only the command register can be reached. Bytes aimed at the other locations are still acknowledged, but writes have no effect and reads return zero. Any command write that leaves the power bit at 0 also wipes the dimming and auxiliary registers. The register contents and one-cycle write strobes go to the mode controller. A one-cycle strobe marks each completed read of the status byte, so the controller can release its latched flags.

Top module: `flash_reg_target`

## Requirements
- R1: After reset, the command, dimming and auxiliary outputs are 0x00, all strobes are low and the data line is released (`sda_pull`=0).
- R2: The device address is {0b01100, `strap_sel`}. With `strap_sel`=2'b01 the write address byte is 0x62. A byte carrying any other address gets no acknowledge, and the transfer that follows changes no register.
- R3: A write transfer (address byte with R/W=0, index byte, data byte) is acknowledged at every byte and stores the data at the index. Index 0 is command, 1 is dimming, 2 is auxiliary and 3 is status.
- R4: In a write burst, each further data byte goes to the next index, and index 3 is followed by index 0.
- R5: Only the two low bits of the index byte are used. For example, 0x06 selects the auxiliary register.
- R6: A read sets the index with a write phase, then a repeated START with R/W=1 returns the byte at that index. Each master acknowledge moves to the next index (3 wraps to 0), and a master no-acknowledge ends the transfer.
- R7: Index 3 is read-only. A write to it is acknowledged and dropped. While powered, a read of it returns `stat_bits`.
- R8: While command bit 7 is 0, bytes aimed at indices 1 to 3 are acknowledged, writes to them are ignored and reads of them return 0x00. The command register can still be read and written.
- R9: A command write with bit 7 = 0 stores the written command value and clears the dimming and auxiliary registers in the same cycle.
- R10: `stat_rd_stb` pulses for one cycle once per status byte sent while powered, in the acknowledge slot after that byte. It stays low for reads made while powered down.
- R11: Each accepted register write raises exactly one one-cycle strobe (`cmd_wstb`, `dim_wstb` or `aux_wstb`), in the cycle the new value first appears. Ignored writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| strap_sel | input | 2 | Low two bits of the device address |
| stat_bits | input | 8 | Status value returned at index 3 |
| sda_pull | output | 1 | 1 = pull the data line low |
| cmd_q | output | 8 | Command register |
| dim_q | output | 8 | Dimming register |
| aux_q | output | 8 | Auxiliary LED register |
| cmd_wstb | output | 1 | Command register written |
| dim_wstb | output | 1 | Dimming register written |
| aux_wstb | output | 1 | Auxiliary register written |
| stat_rd_stb | output | 1 | Status byte was read out |

## Verification
The main function is driven with single writes, a four-byte write burst that runs through the read-only index and wraps to the command register, and an index byte above 3. Together these separate correct index handling from a pointer that neither advances nor masks. A burst read that starts at index 1 and wraps past the status byte checks that master acknowledges advance the index, and that exactly one status strobe is produced. The same accesses are repeated with the power bit cleared, which shows whether gating depends on the current command value. A wrong device address and a changed strap value show that the address compare uses the strap bits and nothing else.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int REG_W   = 8;
  localparam int PTR_W   = 2;
  localparam int PWR_BIT = 7;

  localparam logic [PTR_W-1:0] IDX_CMD  = 2'd0;
  localparam logic [PTR_W-1:0] IDX_DIM  = 2'd1;
  localparam logic [PTR_W-1:0] IDX_AUX  = 2'd2;
  localparam logic [PTR_W-1:0] IDX_STAT = 2'd3;

  typedef enum logic [3:0] {
    BS_IDLE,
    BS_DEV,
    BS_DEV_ACK,
    BS_IDX,
    BS_IDX_ACK,
    BS_WDAT,
    BS_WACK,
    BS_RDAT,
    BS_RACK
  } bus_state_e;
endpackage

// File: rtl/fr_line_sync.sv
module fr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic scl_cur, scl_prv, sda_cur, sda_prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
    end
  end

  assign scl_cur   = scl_pipe[STAGES-1];
  assign scl_prv   = scl_pipe[STAGES];
  assign sda_cur   = sda_pipe[STAGES-1];
  assign sda_prv   = sda_pipe[STAGES];
  assign sda_lvl   = sda_cur;
  assign scl_rise  = scl_cur & ~scl_prv;
  assign scl_fall  = ~scl_cur & scl_prv;
  assign start_det = scl_cur & scl_prv & sda_prv & ~sda_cur;
  assign stop_det  = scl_cur & scl_prv & ~sda_prv & sda_cur;
endmodule

// File: rtl/fr_bus_engine.sv
module fr_bus_engine
  import fr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       dev_addr,
  input  logic [REG_W-1:0] rd_data,
  output logic             sda_pull,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_data,
  output logic             stat_sent
);
  localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  bus_state_e       st, st_n;
  logic [2:0]       cnt, cnt_n;
  logic             got8, got8_n;
  logic [REG_W-1:0] rx_sh, rx_sh_n;
  logic [REG_W-1:0] tx_sh, tx_sh_n;
  logic [PTR_W-1:0] ptr_n;
  logic             rw, rw_n;
  logic             mack, mack_n;
  logic             sent3, sent3_n;
  logic             stat_n;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    got8_n  = got8;
    rx_sh_n = rx_sh;
    tx_sh_n = tx_sh;
    ptr_n   = ptr;
    rw_n    = rw;
    mack_n  = mack;
    sent3_n = sent3;
    stat_n  = 1'b0;
    wr_en   = 1'b0;
    if (stop_det) begin
      st_n = BS_IDLE;
    end else if (start_det) begin
      st_n   = BS_DEV;
      cnt_n  = 3'd0;
      got8_n = 1'b0;
    end else begin
      case (st)
        BS_DEV, BS_IDX, BS_WDAT: begin
          if (scl_rise && !got8) begin
            rx_sh_n = {rx_sh[REG_W-2:0], sda_lvl};
            cnt_n   = cnt + 3'd1;
            if (cnt == 3'd7) got8_n = 1'b1;
          end else if (scl_fall && got8) begin
            got8_n = 1'b0;
            cnt_n  = 3'd0;
            if (st == BS_DEV) begin
              if (rx_sh[7:1] == dev_addr) begin
                st_n = BS_DEV_ACK;
                rw_n = rx_sh[0];
              end else begin
                st_n = BS_IDLE;
              end
            end else if (st == BS_IDX) begin
              st_n  = BS_IDX_ACK;
              ptr_n = rx_sh[PTR_W-1:0];
            end else begin
              st_n  = BS_WACK;
              wr_en = 1'b1;
              ptr_n = ptr + PTR_ONE;
            end
          end
        end
        BS_DEV_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              st_n    = BS_RDAT;
              tx_sh_n = rd_data;
            end else begin
              st_n = BS_IDX;
            end
          end
        end
        BS_IDX_ACK, BS_WACK: begin
          if (scl_fall) st_n = BS_WDAT;
        end
        BS_RDAT: begin
          if (scl_fall) begin
            tx_sh_n = {tx_sh[REG_W-2:0], 1'b1};
            cnt_n   = cnt + 3'd1;
            if (cnt == 3'd7) begin
              st_n    = BS_RACK;
              cnt_n   = 3'd0;
              sent3_n = (ptr == IDX_STAT);
              ptr_n   = ptr + PTR_ONE;
            end
          end
        end
        BS_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
            stat_n = sent3;
          end else if (scl_fall) begin
            if (mack) begin
              st_n    = BS_RDAT;
              tx_sh_n = rd_data;
            end else begin
              st_n = BS_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BS_IDLE;
      cnt       <= 3'd0;
      got8      <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      ptr       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      sent3     <= 1'b0;
      stat_sent <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      got8      <= got8_n;
      rx_sh     <= rx_sh_n;
      tx_sh     <= tx_sh_n;
      ptr       <= ptr_n;
      rw        <= rw_n;
      mack      <= mack_n;
      sent3     <= sent3_n;
      stat_sent <= stat_n;
    end
  end

  assign wr_data  = rx_sh;
  assign sda_pull = (st == BS_DEV_ACK) || (st == BS_IDX_ACK) || (st == BS_WACK) ||
                    ((st == BS_RDAT) && !tx_sh[REG_W-1]);
endmodule

// File: rtl/fr_reg_file.sv
module fr_reg_file
  import fr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] stat_bits,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] dim_q,
  output logic [REG_W-1:0] aux_q,
  output logic             cmd_wstb,
  output logic             dim_wstb,
  output logic             aux_wstb,
  output logic             powered
);
  logic [REG_W-1:0] cmd_n, dim_n, aux_n;
  logic             cw_n, dw_n, aw_n;

  assign powered = cmd_q[PWR_BIT];

  always_comb begin
    cmd_n = cmd_q;
    dim_n = dim_q;
    aux_n = aux_q;
    cw_n  = 1'b0;
    dw_n  = 1'b0;
    aw_n  = 1'b0;
    if (wr_en) begin
      case (idx)
        IDX_CMD: begin
          cmd_n = wr_data;
          cw_n  = 1'b1;
          if (!wr_data[PWR_BIT]) begin
            dim_n = '0;
            aux_n = '0;
          end
        end
        IDX_DIM: if (powered) begin
          dim_n = wr_data;
          dw_n  = 1'b1;
        end
        IDX_AUX: if (powered) begin
          aux_n = wr_data;
          aw_n  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      dim_q <= '0;
      aux_q <= '0;
    end else if (wr_en) begin
      cmd_q <= cmd_n;
      dim_q <= dim_n;
      aux_q <= aux_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wstb <= 1'b0;
      dim_wstb <= 1'b0;
      aux_wstb <= 1'b0;
    end else begin
      cmd_wstb <= cw_n;
      dim_wstb <= dw_n;
      aux_wstb <= aw_n;
    end
  end

  always_comb begin
    case (idx)
      IDX_CMD:  rd_data = cmd_q;
      IDX_DIM:  rd_data = powered ? dim_q : '0;
      IDX_AUX:  rd_data = powered ? aux_q : '0;
      default:  rd_data = powered ? stat_bits : '0;
    endcase
  end
endmodule

// File: rtl/flash_reg_target.sv
module flash_reg_target
  import fr_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h30,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [1:0]       strap_sel,
  input  logic [REG_W-1:0] stat_bits,
  output logic             sda_pull,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] dim_q,
  output logic [REG_W-1:0] aux_q,
  output logic             cmd_wstb,
  output logic             dim_wstb,
  output logic             aux_wstb,
  output logic             stat_rd_stb
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]       dev_addr;
  logic [PTR_W-1:0] ptr;
  logic             wr_en, stat_sent, powered;
  logic [REG_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign dev_addr = {BASE_ADDR[6:2], strap_sel};

  fr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  fr_bus_engine u_eng (
    .clk(clk), .rst_n(rst_int_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .rd_data(rd_data), .sda_pull(sda_pull), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .stat_sent(stat_sent)
  );

  fr_reg_file u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .idx(ptr), .wr_data(wr_data),
    .stat_bits(stat_bits), .rd_data(rd_data), .cmd_q(cmd_q), .dim_q(dim_q),
    .aux_q(aux_q), .cmd_wstb(cmd_wstb), .dim_wstb(dim_wstb), .aux_wstb(aux_wstb),
    .powered(powered)
  );

  assign stat_rd_stb = stat_sent & powered;
endmodule

// File: rtl/fr_target_chk.sv
module fr_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_q,
  input logic [7:0] dim_q,
  input logic [7:0] aux_q,
  input logic       cmd_wstb,
  input logic       dim_wstb,
  input logic       aux_wstb,
  input logic       stat_rd_stb
);
  // R9
  shut_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[7] |-> (dim_q == 8'h00 && aux_q == 8'h00));
  // R8
  dim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dim_wstb || aux_wstb) |-> cmd_q[7]);
  // R11
  dim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dim_q) |-> (dim_wstb || cmd_wstb));
  // R11
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_q) |-> (aux_wstb || cmd_wstb));
  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> cmd_wstb);
  // R11
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wstb, dim_wstb, aux_wstb}));
  // R10
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_stb |=> !stat_rd_stb);
  // R10
  stat_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_stb |-> cmd_q[7]);
endmodule

bind flash_reg_target fr_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .dim_q(dim_q), .aux_q(aux_q),
  .cmd_wstb(cmd_wstb), .dim_wstb(dim_wstb), .aux_wstb(aux_wstb),
  .stat_rd_stb(stat_rd_stb)
);

// File: tb/flash_reg_target_test.sv
module flash_reg_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int QP         = 6;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] sel = 2'b01;
  logic [7:0] stat_in = 8'h00;
  logic sda_pull, cmd_wstb, dim_wstb, aux_wstb, stat_rd_stb;
  logic [7:0] cmd_q, dim_q, aux_q;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pull;
  always #(CLK_PERIOD/2) clk = ~clk;

  flash_reg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .strap_sel(sel),
    .stat_bits(stat_in), .sda_pull(sda_pull), .cmd_q(cmd_q), .dim_q(dim_q),
    .aux_q(aux_q), .cmd_wstb(cmd_wstb), .dim_wstb(dim_wstb), .aux_wstb(aux_wstb),
    .stat_rd_stb(stat_rd_stb)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int n_cmd = 0, n_dim = 0, n_aux = 0, n_stat = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_byte;
  event       rx_evt;

  logic [7:0] m_cmd = 8'h00, m_dim = 8'h00, m_aux = 8'h00;
  int m_ptr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_wstb)    n_cmd++;
      if (dim_wstb)    n_dim++;
      if (aux_wstb)    n_aux++;
      if (stat_rd_stb) n_stat++;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: pops expected read bytes as the design returns them
  initial begin
    forever begin
      @(rx_evt);
      if (exp_q.size() == 0) check("R6 unexpected read byte", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {24'd0, rx_byte}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; wq(QP);
    scl = 1'b1; wq(QP);
    s = sda_bus; wq(QP);
    scl = 1'b0; wq(QP);
  endtask

  task automatic start_cond();
    sda_m = 1'b1; wq(QP);
    scl = 1'b1; wq(QP);
    sda_m = 1'b0; wq(QP);
    scl = 1'b0; wq(QP);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0; wq(QP);
    scl = 1'b1; wq(QP);
    sda_m = 1'b1; wq(4*QP);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      v = {v[6:0], s};
    end
    bus_bit(~give_ack, s);
  endtask

  function automatic logic [6:0] dev_of(input logic [1:0] st);
    return {5'b01100, st};
  endfunction

  // requirement model: R3 R4 R7 R8 R9
  task automatic model_write(input logic [7:0] d);
    case (m_ptr)
      0: begin m_cmd = d; if (!d[7]) begin m_dim = 8'h00; m_aux = 8'h00; end end
      1: if (m_cmd[7]) m_dim = d;
      2: if (m_cmd[7]) m_aux = d;
      default: ;
    endcase
    m_ptr = (m_ptr + 1) % 4;
  endtask

  function automatic logic [7:0] model_read(input int p);
    if (p == 0) return m_cmd;
    if (!m_cmd[7]) return 8'h00;
    if (p == 1) return m_dim;
    if (p == 2) return m_aux;
    return stat_in;
  endfunction

  task automatic wr_burst(input string tag, input logic [7:0] idx, input int n,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3);
    logic ack;
    logic [7:0] dv[4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    start_cond();
    put_byte({dev_of(sel), 1'b0}, ack);
    check({tag, " device ack"}, {31'd0, ack}, 32'd1);
    put_byte(idx, ack);
    check({tag, " index ack"}, {31'd0, ack}, 32'd1);
    m_ptr = int'(idx[1:0]);
    for (int k = 0; k < n; k++) begin
      put_byte(dv[k], ack);
      check({tag, " data ack"}, {31'd0, ack}, 32'd1);
      model_write(dv[k]);
    end
    stop_cond();
  endtask

  task automatic rd_burst(input string tag, input logic [7:0] idx, input int n);
    logic ack;
    logic [7:0] v;
    start_cond();
    put_byte({dev_of(sel), 1'b0}, ack);
    check({tag, " device ack"}, {31'd0, ack}, 32'd1);
    put_byte(idx, ack);
    check({tag, " index ack"}, {31'd0, ack}, 32'd1);
    m_ptr = int'(idx[1:0]);
    start_cond();
    put_byte({dev_of(sel), 1'b1}, ack);
    check({tag, " read address ack"}, {31'd0, ack}, 32'd1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model_read(m_ptr));
      tag_q.push_back({tag, " read byte"});
      m_ptr = (m_ptr + 1) % 4;
      get_byte(k < n - 1, v);
      rx_byte = v;
      -> rx_evt;
    end
    stop_cond();
  endtask

  initial begin
    int c0, d0, a0, s0;
    logic ack;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R1 reset state
    check("R1 cmd reset", {24'd0, cmd_q}, 32'h00);
    check("R1 dim reset", {24'd0, dim_q}, 32'h00);
    check("R1 aux reset", {24'd0, aux_q}, 32'h00);
    check("R1 sda released", {31'd0, sda_pull}, 32'd0);

    // R8 powered down: dimming write acked but ignored, R11 no strobe
    d0 = n_dim;
    wr_burst("R8 shutdown write", 8'h01, 1, 8'h55, 8'h00, 8'h00, 8'h00);
    check("R8 dim unchanged", {24'd0, dim_q}, 32'h00);
    check("R11 no strobe on ignored write", n_dim - d0, 0);
    rd_burst("R8 shutdown read", 8'h01, 1);

    // R3 single writes
    c0 = n_cmd;
    wr_burst("R3 cmd write", 8'h00, 1, 8'h80, 8'h00, 8'h00, 8'h00);
    check("R3 cmd value", {24'd0, cmd_q}, 32'h80);
    check("R11 cmd strobe count", n_cmd - c0, 1);
    wr_burst("R3 dim write", 8'h01, 1, 8'h07, 8'h00, 8'h00, 8'h00);
    check("R3 dim value", {24'd0, dim_q}, 32'h07);

    // R4 burst with wrap; R7 status write discarded
    c0 = n_cmd; d0 = n_dim; a0 = n_aux;
    wr_burst("R4 burst", 8'h02, 4, 8'h85, 8'h99, 8'hC3, 8'h22);
    check("R4 aux value", {24'd0, aux_q}, 32'h85);
    check("R4 wrapped cmd", {24'd0, cmd_q}, 32'hC3);
    check("R4 dim after wrap", {24'd0, dim_q}, 32'h22);
    check("R11 burst strobes", (n_cmd - c0) + (n_dim - d0) + (n_aux - a0), 3);

    // R5 index masking
    wr_burst("R5 masked index", 8'h06, 1, 8'h44, 8'h00, 8'h00, 8'h00);
    check("R5 aux via index 0x06", {24'd0, aux_q}, 32'h44);

    // R6 read burst with wrap, R7 status read, R10 single strobe
    stat_in = 8'hA5;
    s0 = n_stat;
    rd_burst("R6 burst read", 8'h01, 4);
    check("R10 status strobe count", n_stat - s0, 1);
    s0 = n_stat;
    rd_burst("R7 status single read", 8'h03, 1);
    check("R10 status strobe on NACK end", n_stat - s0, 1);

    // R2 wrong address
    start_cond();
    put_byte({7'h35, 1'b0}, ack);
    check("R2 wrong address nack", {31'd0, ack}, 32'd0);
    put_byte(8'h00, ack);
    put_byte(8'h00, ack);
    stop_cond();
    check("R2 cmd untouched", {24'd0, cmd_q}, 32'hC3);

    // R2 strap change
    sel = 2'b11;
    wr_burst("R2 strap address", 8'h01, 1, 8'h11, 8'h00, 8'h00, 8'h00);
    check("R2 dim via strap 11", {24'd0, dim_q}, 32'h11);
    sel = 2'b01;

    // R9 enter shutdown
    wr_burst("R9 shutdown entry", 8'h00, 1, 8'h10, 8'h00, 8'h00, 8'h00);
    check("R9 cmd kept", {24'd0, cmd_q}, 32'h10);
    check("R9 dim cleared", {24'd0, dim_q}, 32'h00);
    check("R9 aux cleared", {24'd0, aux_q}, 32'h00);

    // R8 reads while down, R10 no strobe
    s0 = n_stat;
    rd_burst("R8 shutdown burst read", 8'h01, 4);
    check("R10 no strobe while down", n_stat - s0, 0);
    a0 = n_aux;
    wr_burst("R8 aux write while down", 8'h02, 1, 8'h66, 8'h00, 8'h00, 8'h00);
    check("R8 aux still zero", {24'd0, aux_q}, 32'h00);
    check("R11 no aux strobe while down", n_aux - a0, 0);

    wq(20);
    check("R6 all read bytes consumed", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule